// File: doc/BRIEF.md
# Translation Table Region Selector

The block decides which of two translation table bases serves a 64-bit input address. The low region holds addresses whose upper bits are all zero. The high region holds addresses whose upper bits are all one. Each region's size field gives the number of upper bits that take part in that test. The block is purely combinational and sits in front of a table walker. The walker uses the region select to choose its base register. When the fault flag is raised, the walker abandons the request as a translation fault.

Top-byte-ignore removes the eight most significant address bits from the test. Address bit 55 decides which region's ignore enable applies. A region with a zero size field covers every address that the other region does not claim. When both size fields are non-zero and neither region claims the address, it lies in the gap between them and faults. A per-region disable input turns the selection of that region into a fault.

Top module: `tts_region_sel`

## Requirements
- R1: The ignore enable is taken from tbi1_i when addr_i[55] is 1, and from tbi0_i when it is 0.
- R2: When the chosen ignore enable is 1, address bits 63..56 take no part in either region test; when it is 0 they take part.
- R3: The checked bits of a region with size field t are bit positions p with 64-t <= p and p < 64 (or p < 56 under ignore). If tsz0_i is non-zero and all checked bits for tsz0_i are 0, then sel_o is 0. An empty checked range counts as a match.
- R4: Otherwise, if tsz1_i is non-zero and all checked bits for tsz1_i are 1, then sel_o is 1.
- R5: Otherwise, if tsz0_i is zero, then sel_o is 0.
- R6: Otherwise, if tsz1_i is zero, then sel_o is 1.
- R7: If none of R3 to R6 applies, fault_o is 1 and sel_o is 0.
- R8: When the selected region's disable input is 1, fault_o is 1 and sel_o still names that region. Without a disable or a gap, fault_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 64 | Input address to classify |
| tsz0_i | input | 6 | Low region size field (count of upper bits tested) |
| tsz1_i | input | 6 | High region size field (count of upper bits tested) |
| tbi0_i | input | 1 | Top-byte-ignore enable applied when addr_i[55] is 0 |
| tbi1_i | input | 1 | Top-byte-ignore enable applied when addr_i[55] is 1 |
| dis0_i | input | 1 | Low region disabled |
| dis1_i | input | 1 | High region disabled |
| sel_o | output | 1 | Selected region: 0 low, 1 high |
| fault_o | output | 1 | Translation fault (gap or disabled region) |

## Verification
Both results are due in the same cycle as the stimulus, because no register lies on any path. The bench applies each input vector just after a rising clock edge. It compares sel_o and fault_o at the following falling edge, half a period later, so the outputs have settled and the sample is clear of any edge. The bench sweeps a set of size-field values chosen around the top-byte boundary against every ignore-enable and disable combination and a set of address patterns. For each vector it computes the expected select and fault bit by bit from the priority chain.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned TSZ_W   = 6;
  localparam int unsigned TOP_W   = 8;
  localparam int unsigned TBI_BIT = 55;

  typedef enum logic {
    RGN_LO = 1'b0,
    RGN_HI = 1'b1
  } rgn_e;
endpackage

// File: rtl/tts_range_mask.sv
// Marks the address bits that a region of size tsz_i must test.
module tts_range_mask #(
  parameter int unsigned ADDR_W = tts_pkg::ADDR_W,
  parameter int unsigned TSZ_W  = tts_pkg::TSZ_W,
  parameter int unsigned TOP_W  = tts_pkg::TOP_W
) (
  input  logic [TSZ_W-1:0]  tsz_i,
  input  logic              ign_i,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int unsigned BASE_W = ($clog2(ADDR_W) > TSZ_W) ? $clog2(ADDR_W) : TSZ_W;
  localparam int unsigned CMP_W  = BASE_W + 2;
  localparam logic [CMP_W-1:0] LIM = CMP_W'(ADDR_W);

  logic [CMP_W-1:0] tsz_ext;
  logic [CMP_W-1:0] ign_ext;

  assign tsz_ext = CMP_W'(tsz_i);
  assign ign_ext = ign_i ? CMP_W'(TOP_W) : '0;

  // bit b tested when ADDR_W - tsz <= b < ADDR_W - ign
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    localparam logic [CMP_W-1:0] POS = CMP_W'(b);
    assign mask_o[b] = ((POS + tsz_ext) >= LIM) && ((POS + ign_ext) < LIM);
  end
endmodule

// File: rtl/tts_region_match.sv
// ONES=0: all masked bits zero; ONES=1: all masked bits one.
module tts_region_match #(
  parameter int unsigned ADDR_W = tts_pkg::ADDR_W,
  parameter bit          ONES   = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              hit_o
);
  if (ONES) begin : g_ones
    assign hit_o = &(addr_i | ~mask_i);
  end else begin : g_zero
    assign hit_o = ~|(addr_i & mask_i);
  end
endmodule

// File: rtl/tts_prio.sv
module tts_prio
  import tts_pkg::*;
(
  input  logic [1:0] sized_i,
  input  logic       hit_lo_i,
  input  logic       hit_hi_i,
  input  logic [1:0] dis_i,
  output rgn_e       rgn_o,
  output logic       fault_o
);
  logic gap;

  always_comb begin
    gap   = 1'b0;
    rgn_o = RGN_LO;
    if (sized_i[0] && hit_lo_i)      rgn_o = RGN_LO;
    else if (sized_i[1] && hit_hi_i) rgn_o = RGN_HI;
    else if (!sized_i[0])            rgn_o = RGN_LO;
    else if (!sized_i[1])            rgn_o = RGN_HI;
    else                             gap   = 1'b1;
  end

  always_comb begin
    case (rgn_o)
      RGN_HI:  fault_o = gap | dis_i[1];
      default: fault_o = gap | dis_i[0];
    endcase
  end
endmodule

// File: rtl/tts_region_sel.sv
module tts_region_sel
  import tts_pkg::*;
#(
  parameter int unsigned ADDR_W  = tts_pkg::ADDR_W,
  parameter int unsigned TSZ_W   = tts_pkg::TSZ_W,
  parameter int unsigned TOP_W   = tts_pkg::TOP_W,
  parameter int unsigned TBI_BIT = tts_pkg::TBI_BIT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TSZ_W-1:0]  tsz0_i,
  input  logic [TSZ_W-1:0]  tsz1_i,
  input  logic              tbi0_i,
  input  logic              tbi1_i,
  input  logic              dis0_i,
  input  logic              dis1_i,
  output logic              sel_o,
  output logic              fault_o
);
  localparam int unsigned N_RGN = 2;

  logic                ign;
  logic [TSZ_W-1:0]    tsz   [N_RGN];
  logic [ADDR_W-1:0]   mask  [N_RGN];
  logic [N_RGN-1:0]    hit;
  logic [N_RGN-1:0]    sized;
  rgn_e                rgn;

  // ignore enable picked by the sign-like bit, shared by both tests
  assign ign    = addr_i[TBI_BIT] ? tbi1_i : tbi0_i;
  assign tsz[0] = tsz0_i;
  assign tsz[1] = tsz1_i;

  for (genvar r = 0; r < N_RGN; r++) begin : g_rgn
    assign sized[r] = |tsz[r];

    tts_range_mask #(
      .ADDR_W (ADDR_W),
      .TSZ_W  (TSZ_W),
      .TOP_W  (TOP_W)
    ) i_mask (
      .tsz_i  (tsz[r]),
      .ign_i  (ign),
      .mask_o (mask[r])
    );

    tts_region_match #(
      .ADDR_W (ADDR_W),
      .ONES   (r == 1)
    ) i_match (
      .addr_i (addr_i),
      .mask_i (mask[r]),
      .hit_o  (hit[r])
    );
  end

  tts_prio i_prio (
    .sized_i  (sized),
    .hit_lo_i (hit[0]),
    .hit_hi_i (hit[1]),
    .dis_i    ({dis1_i, dis0_i}),
    .rgn_o    (rgn),
    .fault_o  (fault_o)
  );

  assign sel_o = (rgn == RGN_HI);
endmodule

// File: rtl/tts_region_sel_chk.sv
module tts_region_sel_chk #(
  parameter int unsigned ADDR_W = tts_pkg::ADDR_W,
  parameter int unsigned TSZ_W  = tts_pkg::TSZ_W
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic [TSZ_W-1:0]  tsz0_i,
  input logic [TSZ_W-1:0]  tsz1_i,
  input logic              tbi0_i,
  input logic              tbi1_i,
  input logic              dis0_i,
  input logic              dis1_i,
  input logic              sel_o,
  input logic              fault_o
);
  logic known;
  assign known = !$isunknown({addr_i, tsz0_i, tsz1_i, tbi0_i, tbi1_i,
                              dis0_i, dis1_i, sel_o, fault_o});

  always_comb begin
    if (known) begin
      // R7
      gap_both_sized_chk: assert (!(fault_o && !dis0_i && !dis1_i) ||
                                  (tsz0_i != '0 && tsz1_i != '0))
        else $error("gap fault with an unsized region");
      // R7
      gap_sel_lo_chk: assert (!(fault_o && !dis0_i && !dis1_i) || !sel_o)
        else $error("gap fault must report low region");
      // R3
      zero_addr_lo_chk: assert (!(addr_i == '0 && tsz0_i != '0) ||
                                (!sel_o && (fault_o == dis0_i)))
        else $error("zero address not in low region");
      // R5
      lo_unsized_ok_chk: assert (!(tsz0_i == '0 && !dis0_i && !dis1_i) || !fault_o)
        else $error("fault with unsized low region");
      // R8
      dis_lo_chk: assert (!(dis0_i && !sel_o) || fault_o)
        else $error("disabled low region without fault");
      // R8
      dis_hi_chk: assert (!(dis1_i && sel_o) || fault_o)
        else $error("disabled high region without fault");
    end
  end
endmodule

bind tts_region_sel tts_region_sel_chk #(
  .ADDR_W (ADDR_W),
  .TSZ_W  (TSZ_W)
) i_chk (
  .addr_i  (addr_i),
  .tsz0_i  (tsz0_i),
  .tsz1_i  (tsz1_i),
  .tbi0_i  (tbi0_i),
  .tbi1_i  (tbi1_i),
  .dis0_i  (dis0_i),
  .dis1_i  (dis1_i),
  .sel_o   (sel_o),
  .fault_o (fault_o)
);

// File: tb/test_tts_region_sel.sv
module test_tts_region_sel;
  logic        clk = 1'b0;
  logic [63:0] addr_i = '0;
  logic [5:0]  tsz0_i = '0, tsz1_i = '0;
  logic        tbi0_i = 1'b0, tbi1_i = 1'b0, dis0_i = 1'b0, dis1_i = 1'b0;
  logic        sel_o, fault_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  always #5 clk = ~clk;

  tts_region_sel i_tts_region_sel (
    .addr_i, .tsz0_i, .tsz1_i, .tbi0_i, .tbi1_i,
    .dis0_i, .dis1_i, .sel_o, .fault_o
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // reference from the requirements
  task automatic model(input logic [63:0] a, input int t0, input int t1,
                       input bit b0, input bit b1, input bit d0, input bit d1,
                       output bit es, output bit ef, output string tag);
    bit ign = a[55] ? b1 : b0;      // R1
    int top = ign ? 56 : 64;        // R2
    bit in0 = 1'b1, in1 = 1'b1, gap = 1'b0;
    for (int p = 64 - t0; p < top; p++) if (a[p]) in0 = 1'b0;
    for (int p = 64 - t1; p < top; p++) if (!a[p]) in1 = 1'b0;
    if (t0 != 0 && in0)      begin es = 0; tag = "R3"; end
    else if (t1 != 0 && in1) begin es = 1; tag = "R4"; end
    else if (t0 == 0)        begin es = 0; tag = "R5"; end
    else if (t1 == 0)        begin es = 1; tag = "R6"; end
    else begin es = 0; gap = 1; tag = "R7"; end
    ef = gap | (es ? d1 : d0);
    if (!gap && (es ? d1 : d0)) tag = {tag, " R8"};
    if (ign) tag = {tag, " R2"};
  endtask

  task automatic run(input logic [63:0] a, input int t0, input int t1,
                     input bit b0, input bit b1, input bit d0, input bit d1,
                     input bit es, input bit ef, input string tag);
    @(posedge clk);
    addr_i <= a; tsz0_i <= 6'(t0); tsz1_i <= 6'(t1);
    tbi0_i <= b0; tbi1_i <= b1; dis0_i <= d0; dis1_i <= d1;
    @(negedge clk);
    checks++;
    if (sel_o !== es || fault_o !== ef) begin
      failures++;
      $display("FAIL %s addr=%h tsz0=%0d tsz1=%0d tbi=%b%b dis=%b%b sel=%b exp %b fault=%b exp %b",
               tag, a, t0, t1, b1, b0, d1, d0, sel_o, es, fault_o, ef);
    end
  endtask

  task automatic swept(input logic [63:0] a, input int t0, input int t1,
                       input bit b0, input bit b1, input bit d0, input bit d1);
    bit es, ef;
    string tag;
    model(a, t0, t1, b0, b1, d0, d1, es, ef, tag);
    run(a, t0, t1, b0, b1, d0, d1, es, ef, tag);
  endtask

  function automatic logic [63:0] pat(input int k, input int t0);
    case (k)
      0: return 64'h0;
      1: return '1;
      2: return 64'hFF00_0000_0000_1234;
      3: return 64'h00FF_FFFF_FFFF_F000;
      4: return 64'h0080_0000_0000_0000;
      5: return 64'hFF7F_FFFF_FFFF_FFFF;
      6: return lcg;
      default: return (t0 != 0) ? (64'h1 << (64 - t0)) : 64'h8000_0000_0000_0000;
    endcase
  endfunction

  initial begin
    int tl[8] = '{0, 1, 8, 9, 20, 33, 55, 63};
    // reset-like idle vector: both sizes zero -> low region (R5)
    run(64'h0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R5 idle");
    // R1: bit55=1 uses tbi1
    run(64'h12FF_FFFF_0000_0000, 16, 16, 0, 1, 0, 0, 1'b1, 1'b0, "R1 hi enable");
    run(64'h12FF_FFFF_0000_0000, 16, 16, 1, 0, 0, 0, 1'b0, 1'b1, "R1 lo enable ignored");
    // R2: top byte excluded only when enabled
    run(64'hAB00_0000_0000_1000, 16, 16, 1, 0, 0, 0, 1'b0, 1'b0, "R2 ignored byte");
    run(64'hAB00_0000_0000_1000, 16, 16, 0, 0, 0, 0, 1'b0, 1'b1, "R2 byte tested");
    // R3: empty checked range
    run(64'h7700_0000_0000_0000, 8, 8, 1, 0, 0, 0, 1'b0, 1'b0, "R3 empty range");
    // R8: disabled high region
    run('1, 0, 16, 0, 0, 0, 1, 1'b1, 1'b1, "R8 high disabled");
    run(64'h0, 16, 16, 0, 0, 1, 0, 1'b0, 1'b1, "R8 low disabled");
    for (int i0 = 0; i0 < 8; i0++)
      for (int i1 = 0; i1 < 8; i1++)
        for (int tb = 0; tb < 4; tb++)
          for (int ds = 0; ds < 4; ds++)
            for (int k = 0; k < 8; k++) begin
              lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
              swept(pat(k, tl[i0]), tl[i0], tl[i1], tb[0], tb[1], ds[0], ds[1]);
            end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule